// File: doc/BRIEF.md
# Latched-Digit Seven-Segment Refresh Writer

This block feeds a four-digit, seven-segment display whose segments keep their state once written, the way a charged capacitor holds its charge, so the display is not strobed. All digits share one 7-bit segment data bus. Each digit has its own write-enable line. When a digit's enable is high, the digit copies the bus into its storage. When the enable is low, the digit keeps the last pattern written to it.

A slow tick from outside, nominally once per second, starts one write slot. At the start of the slot the block samples the BCD value of the current digit and encodes it onto the bus. It waits a few clock cycles so the bus can settle, then raises that digit's enable for a set number of cycles. After that it moves on to the next digit. A full pass over the four digits therefore takes four ticks, which rewrites every digit before its stored state decays. A separator-dot output is high whenever any enable is high, so the dots pulse once per slot.

Top module: `seg_refresh_writer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `wen_o`, `dot_o` and `seg_o` to zero from the next cycle onward. The first slot after reset writes digit 0.
- R2: Bus bit 0 is segment a and bit 6 is segment g, and a 1 means the segment is set. BCD codes 0..9 map to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R3: Input codes 10 to 15 produce the blank pattern 0x00.
- R4: When `tick_i` is high at an edge while no slot is running, a slot starts. At that edge the block samples the nibble of the current digit (digit k sits at `digits_i[4k+3:4k]`), and `seg_o` shows its pattern from the next cycle.
- R5: The enable rises SETUP_CYCLES cycles after `seg_o` is updated and stays high for exactly PULSE_CYCLES consecutive cycles.
- R6: At most one bit of `wen_o` is high at any time. Successive slots address digits 0, 1, 2, 3, then wrap to 0.
- R7: `seg_o` stays unchanged while an enable is high, and it holds its value after the pulse until the next slot starts. A change on `digits_i` after the sampling edge has no effect on the slot in progress.
- R8: `dot_o` equals the OR of the four enables.
- R9: A tick that arrives while a slot is in its setup or enable phase is ignored. It starts no extra slot and no digit is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Slot start request, one pulse per refresh step |
| digits_i | input | 16 | Four BCD digits, digit k at bits 4k+3..4k |
| seg_o | output | 7 | Shared segment data bus, bit 0 = a ... bit 6 = g |
| wen_o | output | 4 | Per-digit write enables |
| dot_o | output | 1 | Separator dots, OR of the enables |

## Verification
Two events can fall in the same cycle: a new tick, and the setup or enable phase of a slot that is still running. The most delicate case is a tick sampled on the edge that ends the enable pulse. The bench provokes this on purpose. It raises the tick during the enable phase, and also on the final enable cycle, while it scrambles `digits_i` in the middle of the slot. It then judges the outcome against its own model in four ways:
- the pulse still lasts PULSE_CYCLES cycles;
- the bus keeps the pattern sampled at the start of the slot;
- no extra slot appears;
- the following tick addresses the next digit in order.

// File: rtl/seg_refresh_writer.sv
module seg_refresh_writer #(
  parameter int NUM_DIGITS   = 4,
  parameter int SETUP_CYCLES = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [NUM_DIGITS*4-1:0] digits_i,
  output logic [6:0]              seg_o,
  output logic [NUM_DIGITS-1:0]   wen_o,
  output logic                    dot_o
);
  localparam int IDX_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int CNT_MAX = (SETUP_CYCLES > PULSE_CYCLES) ? SETUP_CYCLES : PULSE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE} phase_t;

  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       seg_q;
  logic [3:0]       cur_bcd;

  function automatic logic [6:0] bcd_to_seg(input logic [3:0] v);
    case (v)
      4'd0: bcd_to_seg = 7'h3F;
      4'd1: bcd_to_seg = 7'h06;
      4'd2: bcd_to_seg = 7'h5B;
      4'd3: bcd_to_seg = 7'h4F;
      4'd4: bcd_to_seg = 7'h66;
      4'd5: bcd_to_seg = 7'h6D;
      4'd6: bcd_to_seg = 7'h7D;
      4'd7: bcd_to_seg = 7'h07;
      4'd8: bcd_to_seg = 7'h7F;
      4'd9: bcd_to_seg = 7'h6F;
      default: bcd_to_seg = 7'h00;
    endcase
  endfunction

  assign cur_bcd = digits_i[int'(idx_q)*4 +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      seg_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (tick_i) begin
          seg_q   <= bcd_to_seg(cur_bcd);
          cnt_q   <= '0;
          phase_q <= PH_SETUP;
        end
        PH_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYCLES - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_PULSE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt_q == CNT_W'(PULSE_CYCLES - 1)) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
            idx_q   <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    wen_o = '0;
    if (phase_q == PH_PULSE) wen_o[idx_q] = 1'b1;
  end

  assign seg_o = seg_q;
  assign dot_o = |wen_o;
endmodule

// File: rtl/seg_refresh_writer_chk.sv
module seg_refresh_writer_chk #(
  parameter int NUM_DIGITS   = 4,
  parameter int SETUP_CYCLES = 2,
  parameter int PULSE_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick_i,
  input logic [NUM_DIGITS*4-1:0] digits_i,
  input logic [6:0]            seg_o,
  input logic [NUM_DIGITS-1:0] wen_o,
  input logic                  dot_o
);
  localparam int HW = $clog2(PULSE_CYCLES + 2);

  logic [HW-1:0]         hi_cnt_q;
  logic [NUM_DIGITS-1:0] last_wen_q;
  logic                  seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q   <= '0;
      last_wen_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      hi_cnt_q <= (|wen_o) ? hi_cnt_q + 1'b1 : '0;
      if (|wen_o) begin
        last_wen_q <= wen_o;
        seen_q     <= 1'b1;
      end
    end
  end

  function automatic logic [NUM_DIGITS-1:0] rot1(input logic [NUM_DIGITS-1:0] v);
    rot1 = {v[NUM_DIGITS-2:0], v[NUM_DIGITS-1]};
  endfunction

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (wen_o == '0 && seg_o == 7'h00));

  // R6
  single_enable_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wen_o));

  // R6
  round_robin_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(|wen_o) && seen_q) |-> (wen_o == rot1(last_wen_q)));

  // R7
  bus_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (|wen_o) |-> $stable(seg_o));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(|wen_o) && !$past(rst)) |-> (hi_cnt_q == HW'(PULSE_CYCLES)));

  // R5
  pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
    hi_cnt_q <= HW'(PULSE_CYCLES));
endmodule

bind seg_refresh_writer seg_refresh_writer_chk #(
  .NUM_DIGITS(NUM_DIGITS), .SETUP_CYCLES(SETUP_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (.*);

// File: tb/test_seg_refresh_writer.sv
module test_seg_refresh_writer;
  localparam int ND = 4;
  localparam int S  = 2;
  localparam int P  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic [15:0]   digits_i = '0;
  logic [6:0]    seg_o;
  logic [3:0]    wen_o;
  logic          dot_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_idx = 0;
  int seed_dummy;

  always #2 clk = ~clk;

  seg_refresh_writer #(.NUM_DIGITS(ND), .SETUP_CYCLES(S), .PULSE_CYCLES(P)) i_seg_refresh_writer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .digits_i(digits_i),
    .seg_o(seg_o), .wen_o(wen_o), .dot_o(dot_o));

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    logic [6:0] tbl [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                             7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    ref_seg = (v < 4'd10) ? tbl[v] : 7'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // late_k: cycle index at which a stray tick is driven (-1 for none)
  task automatic run_slot(input bit scramble, input int late_k, input string req);
    logic [3:0] val;
    logic [3:0] ew;
    @(negedge clk);
    val = digits_i[exp_idx*4 +: 4];
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    for (int k = 0; k <= S + P + 1; k++) begin
      ew = (k >= S && k < S + P) ? 4'(1 << exp_idx) : 4'h0;
      chk(seg_o == ref_seg(val), {req, " R4 R7 seg"}, 32'(seg_o), 32'(ref_seg(val)));
      chk(wen_o == ew, {req, " R5 R6 wen"}, 32'(wen_o), 32'(ew));
      chk(dot_o == (|ew), {req, " R8 dot"}, 32'(dot_o), 32'(|ew));
      if (scramble) digits_i = 16'($urandom);
      tick_i = (k == late_k);
      @(negedge clk);
    end
    tick_i = 1'b0;
    exp_idx = (exp_idx + 1) % ND;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    seed_dummy = $urandom(32'h5EC7);
    digits_i = 16'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(wen_o == 4'h0, "R1 wen", 32'(wen_o), 0);
    chk(dot_o == 1'b0, "R1 dot", 32'(dot_o), 0);
    chk(seg_o == 7'h00, "R1 seg", 32'(seg_o), 0);
    rst = 1'b0;

    // R2 every decimal code, one per slot
    for (int v = 0; v < 10; v++) begin
      digits_i = {4{4'(v)}};
      run_slot(1'b0, -1, "R2");
    end
    // R3 blank codes
    for (int v = 10; v < 16; v++) begin
      digits_i = {4{4'(v)}};
      run_slot(1'b0, -1, "R3");
    end

    // R7 data held in idle with inputs changing
    digits_i = 16'h9999;
    run_slot(1'b0, -1, "R7");
    for (int i = 0; i < 6; i++) begin
      digits_i = 16'($urandom);
      @(negedge clk);
      chk(seg_o == 7'h6F, "R7 hold idle", 32'(seg_o), 32'h6F);
      chk(wen_o == 4'h0, "R7 idle wen", 32'(wen_o), 0);
    end

    // R9 stray tick during pulse, and on final enable cycle
    digits_i = 16'($urandom);
    run_slot(1'b1, S, "R9");
    digits_i = 16'($urandom);
    run_slot(1'b1, S + P - 1, "R9 edge");
    digits_i = 16'($urandom);
    run_slot(1'b1, 0, "R9 setup");

    // R1 reset during pulse restarts at digit 0
    digits_i = 16'h1234;
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (S + 1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(wen_o == 4'h0, "R1 mid reset wen", 32'(wen_o), 0);
    chk(seg_o == 7'h00, "R1 mid reset seg", 32'(seg_o), 0);
    exp_idx = 0;
    run_slot(1'b0, -1, "R1 R6 restart");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int lk;
      digits_i = 16'($urandom);
      case ($urandom % 4)
        0: lk = -1;
        1: lk = S + ($urandom % P);
        2: lk = $urandom % S;
        default: lk = S + P - 1;
      endcase
      run_slot(1'($urandom), lk, "R6 rand");
      repeat ($urandom % 3) @(negedge clk);
    end

    finish_run();
  end
endmodule